// File: doc/BRIEF.md
# Serial Configuration Port with Field-Synchronised Commit

This block is a write-only, three-wire serial port that loads a bank of 6-bit configuration registers for a video timing generator. A host lowers the select line `sl_n` and clocks in an 8-bit start address, least significant bit first, on rising edges of `sck`. Each following group of six bits is a data word, also least significant bit first. The first word goes to the start address. Every later complete word goes to the next address up. A word that is cut short when select rises is discarded. This covers both trailing padding from 16-bit hosts and aborted transfers.

Every word lands in a staging register first. Registers of the immediate class (addresses 0 to 7 by default, set by a parameter mask) copy staging to live when `sl_n` rises. Registers of the deferred class wait for the frame sync `vd`. After the leading edge of `vd`, the block counts leading edges of the line sync `hd`, and copies staging to live on the edge selected by the line register. Two control fields sit in immediate-class registers. One is a hold bit that suspends deferred commits. The other is a polarity bit that chooses whether the leading edge of `vd`/`hd` is the falling edge or the rising edge.

All inputs are asynchronous to `clk` and are resynchronised with two flip-flops. The deframer has states IDLE, ADDR and DATA. It moves IDLE→ADDR on the falling edge of select. It moves ADDR→DATA after the eighth address bit and stays in DATA after each complete word. ADDR→IDLE and DATA→IDLE happen on the rising edge of select. The commit sequencer has states WAIT_VD and COUNT. It moves WAIT_VD→COUNT on a leading `vd` edge and COUNT→COUNT (restart) on a new leading `vd` edge. It moves COUNT→WAIT_VD on the `hd` edge that matches the line register.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset every live register reads 0. Register i occupies bits [6i+5:6i] of `live_regs`.
- R2: While `sl_n` is low, `sdata` is sampled on rising `sck`. The first 8 bits form the start address (bit 0 first) and the next 6 bits form the data word (bit 0 first).
- R3: While `sl_n` stays low, each further complete 6-bit word is written to the address one above the previous word's address.
- R4: Bits that do not complete a 6-bit word before `sl_n` rises, including 2 padding bits after a single word, change no register.
- R5: Words aimed at an address of 64 or above change no register.
- R6: An immediate-class register (addresses 0–7) shows its new value only after `sl_n` rises, and not while the frame is still open.
- R7: A deferred-class register (addresses 8–63) is not changed by the rise of `sl_n` or by the `vd` leading edge. With line value 0 it takes its staged value at the first `hd` leading edge after the `vd` leading edge.
- R8: Register 1 holds a line number N. The deferred commit happens at the (N+1)-th `hd` leading edge after the `vd` leading edge, and at no earlier edge.
- R9: While bit 0 of register 0 is 1, deferred-class registers keep their live values. Once the bit is back at 0, the staged values commit in a later field.
- R10: Bit 1 of register 0 set to 0 makes falling edges of `vd`/`hd` the leading edges. Set to 1, it makes rising edges the leading edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial bit clock (asynchronous) |
| sdata | input | 1 | Serial data (asynchronous) |
| sl_n | input | 1 | Active-low frame select (asynchronous) |
| vd | input | 1 | Frame sync (asynchronous) |
| hd | input | 1 | Line sync (asynchronous) |
| live_regs | output | NUM_REGS*DATA_W (384) | Live register contents, register i at [6i+5:6i] |

## Verification
The bench uses the default build: 64 registers of 6 bits, an 8-bit address, and addresses 0–7 in the immediate class. With only 64 registers behind a 256-value address, random start addresses between 2 and 70 with up to three words per frame run off the end of the bank, which exercises the address cut-off. Random runs also cross the boundary between the two commit classes inside one frame. A line register of only 6 bits keeps deferred commits within a few sync pulses per field. This lets the bench probe the line before the commit edge, the commit edge itself, the hold bit and both sync polarities in a short run.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    typedef enum logic [1:0] {
        DF_IDLE,
        DF_ADDR,
        DF_DATA
    } deframe_state_e;

    typedef enum logic {
        FC_WAIT_VD,
        FC_COUNT
    } field_state_e;

endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
            hist_q <= RST_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign rise = sync_q & ~hist_q;
    assign fall = ~sync_q & hist_q;

endmodule

// File: rtl/cfg_deframer.sv
module cfg_deframer
    import cfg_port_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              sdata,
    input  logic              sl_fall,
    input  logic              sl_rise,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int               MAX_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int               CNT_W  = $clog2(MAX_W);
    localparam logic [CNT_W-1:0] A_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] D_LAST = CNT_W'(DATA_W - 1);

    deframe_state_e    st_q, st_nx;
    logic [2:0]        sck_s;
    logic [1:0]        sd_s;
    logic              sck_rise;
    logic              bit_in;
    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] addr_sh;
    logic [DATA_W-1:0] data_sh;
    logic [ADDR_W-1:0] cur_addr;

    // input resynchronisation, same depth as the select path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_s <= '0;
            sd_s  <= '0;
        end else begin
            sck_s <= {sck_s[1:0], sck};
            sd_s  <= {sd_s[0], sdata};
        end
    end

    assign sck_rise = sck_s[1] & ~sck_s[2];
    assign bit_in   = sd_s[1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DF_IDLE;
        else        st_q <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            DF_IDLE: if (sl_fall) st_nx = DF_ADDR;
            DF_ADDR: begin
                if (sl_rise)                              st_nx = DF_IDLE;
                else if (sck_rise && bit_cnt == A_LAST)   st_nx = DF_DATA;
            end
            DF_DATA: if (sl_rise) st_nx = DF_IDLE;
            default: st_nx = DF_IDLE;
        endcase
    end

    // shift path and write strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            addr_sh  <= '0;
            data_sh  <= '0;
            cur_addr <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (st_q == DF_IDLE || sl_rise) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                if (st_q == DF_ADDR) begin
                    addr_sh <= {bit_in, addr_sh[ADDR_W-1:1]};
                    if (bit_cnt == A_LAST) begin
                        cur_addr <= {bit_in, addr_sh[ADDR_W-1:1]};
                        bit_cnt  <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end else begin
                    data_sh <= {bit_in, data_sh[DATA_W-1:1]};
                    if (bit_cnt == D_LAST) begin
                        wr_en    <= 1'b1;
                        wr_addr  <= cur_addr;
                        wr_data  <= {bit_in, data_sh[DATA_W-1:1]};
                        cur_addr <= cur_addr + 1'b1;
                        bit_cnt  <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cfg_field_commit.sv
module cfg_field_commit
    import cfg_port_pkg::*;
#(
    parameter int LINE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vd_rise,
    input  logic              vd_fall,
    input  logic              hd_rise,
    input  logic              hd_fall,
    input  logic              pol_high,
    input  logic              prevent,
    input  logic              pending,
    input  logic [LINE_W-1:0] upd_line,
    output logic              vd_commit
);

    field_state_e      st_q, st_nx;
    logic [LINE_W-1:0] line_cnt;
    logic              vd_lead;
    logic              hd_lead;
    logic              line_hit;

    assign vd_lead  = pol_high ? vd_rise : vd_fall;
    assign hd_lead  = pol_high ? hd_rise : hd_fall;
    assign line_hit = (line_cnt == upd_line);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FC_WAIT_VD;
        else        st_q <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            FC_WAIT_VD: if (vd_lead) st_nx = FC_COUNT;
            FC_COUNT: begin
                if (vd_lead)                  st_nx = FC_COUNT;
                else if (hd_lead && line_hit) st_nx = FC_WAIT_VD;
            end
            default: st_nx = FC_WAIT_VD;
        endcase
    end

    // output
    always_comb begin
        vd_commit = (st_q == FC_COUNT) && !vd_lead && hd_lead && line_hit
                    && !prevent && pending;
    end

    // line counter, restarted by every leading frame sync
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_cnt <= '0;
        end else if (vd_lead) begin
            line_cnt <= '0;
        end else if (st_q == FC_COUNT && hd_lead && line_cnt != '1) begin
            line_cnt <= line_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
    parameter int                  NUM_REGS = 64,
    parameter int                  DATA_W   = 6,
    parameter int                  ADDR_W   = 8,
    parameter logic [NUM_REGS-1:0] SL_MASK  = NUM_REGS'('hFF),
    parameter int                  CTRL_IDX = 0,
    parameter int                  LINE_IDX = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         sl_rise,
    input  logic                         vd_commit,
    output logic [NUM_REGS*DATA_W-1:0]   live_flat,
    output logic                         pending,
    output logic                         prevent,
    output logic                         pol_high,
    output logic [DATA_W-1:0]            upd_line
);

    localparam int IDX_W = $clog2(NUM_REGS);

    logic             wr_hit;
    logic [IDX_W-1:0] wr_idx;

    assign wr_hit = wr_en && (wr_addr < ADDR_W'(NUM_REGS));
    assign wr_idx = wr_addr[IDX_W-1:0];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [DATA_W-1:0] stg_q;
        logic [DATA_W-1:0] live_q;
        logic              load;

        if (SL_MASK[i]) begin : g_sl
            assign load = sl_rise;
        end else begin : g_vd
            assign load = vd_commit;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q  <= '0;
                live_q <= '0;
            end else begin
                if (wr_hit && wr_idx == IDX_W'(i)) stg_q <= wr_data;
                if (load) live_q <= stg_q;
            end
        end

        assign live_flat[i*DATA_W +: DATA_W] = live_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else begin
            if (vd_commit) pending <= 1'b0;
            if (wr_hit && !SL_MASK[wr_idx]) pending <= 1'b1;
        end
    end

    assign prevent  = live_flat[CTRL_IDX*DATA_W];
    assign pol_high = live_flat[CTRL_IDX*DATA_W + 1];
    assign upd_line = live_flat[LINE_IDX*DATA_W +: DATA_W];

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
    parameter int                  NUM_REGS = 64,
    parameter int                  DATA_W   = 6,
    parameter int                  ADDR_W   = 8,
    parameter logic [NUM_REGS-1:0] SL_MASK  = NUM_REGS'('hFF),
    parameter int                  CTRL_IDX = 0,
    parameter int                  LINE_IDX = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sck,
    input  logic                       sdata,
    input  logic                       sl_n,
    input  logic                       vd,
    input  logic                       hd,
    output logic [NUM_REGS*DATA_W-1:0] live_regs
);

    logic [2:0]        ev_rise, ev_fall;
    logic              sl_rise, sl_fall;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              vd_commit;
    logic              pending;
    logic              prevent;
    logic              pol_high;
    logic [DATA_W-1:0] upd_line;

    // bit 0 select, bit 1 frame sync, bit 2 line sync
    cfg_sync_edge #(.W(3), .RST_VAL(3'b111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({hd, vd, sl_n}),
        .rise  (ev_rise),
        .fall  (ev_fall)
    );

    assign sl_rise = ev_rise[0];
    assign sl_fall = ev_fall[0];

    cfg_deframer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_deframe (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (sck),
        .sdata   (sdata),
        .sl_fall (sl_fall),
        .sl_rise (sl_rise),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    cfg_field_commit #(.LINE_W(DATA_W)) u_field (
        .clk       (clk),
        .rst_n     (rst_n),
        .vd_rise   (ev_rise[1]),
        .vd_fall   (ev_fall[1]),
        .hd_rise   (ev_rise[2]),
        .hd_fall   (ev_fall[2]),
        .pol_high  (pol_high),
        .prevent   (prevent),
        .pending   (pending),
        .upd_line  (upd_line),
        .vd_commit (vd_commit)
    );

    cfg_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .SL_MASK  (SL_MASK),
        .CTRL_IDX (CTRL_IDX),
        .LINE_IDX (LINE_IDX)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sl_rise   (sl_rise),
        .vd_commit (vd_commit),
        .live_flat (live_regs),
        .pending   (pending),
        .prevent   (prevent),
        .pol_high  (pol_high),
        .upd_line  (upd_line)
    );

endmodule

// File: rtl/cfg_port_checker.sv
module cfg_port_checker #(
    parameter int                  NUM_REGS = 64,
    parameter int                  DATA_W   = 6,
    parameter logic [NUM_REGS-1:0] SL_MASK  = NUM_REGS'('hFF)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_REGS*DATA_W-1:0] live_flat,
    input logic                       sl_rise,
    input logic                       vd_commit,
    input logic                       pending,
    input logic                       prevent,
    input logic                       wr_en
);

    logic [NUM_REGS*DATA_W-1:0] sl_bits;

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            for (int b = 0; b < DATA_W; b++) begin
                sl_bits[i*DATA_W + b] = SL_MASK[i];
            end
        end
    end

    // R6
    sl_class_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(live_flat & sl_bits) |-> $past(sl_rise));

    // R7
    vd_class_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(live_flat & ~sl_bits) |-> $past(vd_commit));

    // R7
    pending_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> $past(vd_commit));

    // R9
    prevent_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vd_commit |-> !prevent);

    // R3
    word_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

endmodule

bind serial_cfg_port cfg_port_checker #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .SL_MASK  (SL_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .live_flat (live_regs),
    .sl_rise   (sl_rise),
    .vd_commit (vd_commit),
    .pending   (pending),
    .prevent   (prevent),
    .wr_en     (wr_en)
);

// File: tb/serial_cfg_port_test.sv
`timescale 1ns/1ps
module serial_cfg_port_test;

    localparam int NR = 64;
    localparam int DW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic sdata = 1'b0;
    logic sl_n = 1'b1;
    logic vd = 1'b1;
    logic hd = 1'b1;
    logic [NR*DW-1:0] live;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [DW-1:0] stg [NR];
    logic [DW-1:0] lv  [NR];
    logic [DW-1:0] fw  [8];
    bit armed = 1'b0;
    int line_k = 0;

    always #2.5 clk = ~clk;

    serial_cfg_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (sck),
        .sdata     (sdata),
        .sl_n      (sl_n),
        .vd        (vd),
        .hd        (hd),
        .live_regs (live)
    );

    function automatic bit pol_m();
        return lv[0][1];
    endfunction

    function automatic bit prev_m();
        return lv[0][0];
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(bit b);
        sdata = b;
        tick(3);
        sck = 1'b1;
        tick(3);
        sck = 1'b0;
        tick(2);
    endtask

    task automatic frame_open(int addr);
        sl_n = 1'b0;
        tick(4);
        for (int i = 0; i < 8; i++) send_bit(((addr >> i) & 1) != 0);
    endtask

    task automatic frame_words(int start, int n);
        for (int w = 0; w < n; w++) begin
            for (int b = 0; b < DW; b++) send_bit(fw[w][b]);
            if (start + w < NR) stg[start + w] = fw[w];
        end
    endtask

    task automatic frame_tail(int nbits);
        for (int i = 0; i < nbits; i++) send_bit($urandom_range(0, 1) != 0);
    endtask

    task automatic frame_close();
        tick(2);
        sl_n = 1'b1;
        tick(8);
        for (int i = 0; i < 8; i++) lv[i] = stg[i];
        vd = pol_m() ? 1'b0 : 1'b1;
        hd = pol_m() ? 1'b0 : 1'b1;
        tick(4);
    endtask

    task automatic write1(int addr, logic [DW-1:0] d, int pad);
        fw[0] = d;
        frame_open(addr);
        frame_words(addr, 1);
        frame_tail(pad);
        frame_close();
    endtask

    task automatic vd_pulse();
        vd = pol_m() ? 1'b1 : 1'b0;
        tick(6);
        vd = pol_m() ? 1'b0 : 1'b1;
        tick(6);
        armed = 1'b1;
        line_k = 0;
    endtask

    task automatic hd_assert();
        hd = pol_m() ? 1'b1 : 1'b0;
        tick(6);
        if (armed) begin
            if (line_k == int'(lv[1])) begin
                if (!prev_m()) for (int i = 8; i < NR; i++) lv[i] = stg[i];
                armed = 1'b0;
            end else if (line_k < 63) begin
                line_k++;
            end
        end
    endtask

    task automatic hd_release();
        hd = pol_m() ? 1'b0 : 1'b1;
        tick(6);
    endtask

    task automatic field(int nlines);
        vd_pulse();
        for (int k = 0; k < nlines; k++) begin
            hd_assert();
            hd_release();
        end
    endtask

    task automatic check_reg(int idx, logic [DW-1:0] exp, string tag);
        logic [DW-1:0] got;
        got = live[idx*DW +: DW];
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s reg %0d actual=%h expected=%h", tag, idx, got, exp);
        end
    endtask

    task automatic check_all(string tag);
        int bad;
        bad = -1;
        checks++;
        for (int i = 0; i < NR; i++) begin
            if (bad < 0 && live[i*DW +: DW] !== lv[i]) bad = i;
        end
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s reg %0d actual=%h expected=%h", tag, bad,
                     live[bad*DW +: DW], lv[bad]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < NR; i++) begin
            stg[i] = '0;
            lv[i]  = '0;
        end
        tick(5);
        rst_n = 1'b1;
        tick(6);

        // R1 reset state
        check_all("R1 reset");

        // R2 R4 R6 single word into immediate register with 2 padding bits
        fw[0] = 6'h2A;
        frame_open(3);
        frame_words(3, 1);
        frame_tail(2);
        tick(4);
        check_reg(3, 6'h00, "R6 before select rise");
        frame_close();
        check_reg(3, 6'h2A, "R2 R6 after select rise");
        check_reg(4, 6'h00, "R4 padding ignored");

        // R7 deferred register
        write1(10, 6'h15, 0);
        check_reg(10, 6'h00, "R7 not at select rise");
        vd_pulse();
        check_reg(10, 6'h00, "R7 not at vd");
        hd_assert();
        check_reg(10, 6'h15, "R7 first hd edge");
        hd_release();

        // R8 line select = 2
        write1(1, 6'd2, 0);
        write1(20, 6'h33, 2);
        vd_pulse();
        for (int k = 0; k < 2; k++) begin
            hd_assert();
            hd_release();
            check_reg(20, 6'h00, "R8 early line");
        end
        hd_assert();
        check_reg(20, 6'h33, "R8 selected line");
        hd_release();

        // R3 R4 burst across classes, trailing partial word
        fw[0] = 6'h01; fw[1] = 6'h02; fw[2] = 6'h03; fw[3] = 6'h04;
        frame_open(6);
        frame_words(6, 4);
        frame_tail(3);
        frame_close();
        check_all("R3 R4 burst after select");
        check_reg(8, 6'h00, "R3 deferred part waits");
        field(4);
        check_all("R3 burst after field");
        check_reg(10, 6'h15, "R4 partial word dropped");

        // R9 hold bit
        write1(0, 6'h01, 0);
        write1(30, 6'h3F, 0);
        field(4);
        check_reg(30, 6'h00, "R9 held");
        write1(0, 6'h00, 0);
        field(4);
        check_reg(30, 6'h3F, "R9 released");

        // R10 active-high syncs
        write1(0, 6'h02, 0);
        write1(1, 6'd0, 0);
        write1(41, 6'h2C, 0);
        vd_pulse();
        check_reg(41, 6'h00, "R10 before hd");
        hd_assert();
        check_reg(41, 6'h2C, "R10 rising edge leads");
        hd_release();

        // R5 out-of-range addresses
        fw[0] = 6'h11; fw[1] = 6'h22; fw[2] = 6'h33;
        frame_open(62);
        frame_words(62, 3);
        frame_close();
        write1(200, 6'h3E, 0);
        field(2);
        check_all("R5 cut-off");

        // random mix
        for (int it = 0; it < 40; it++) begin
            int a;
            int n;
            a = 2 + $urandom_range(0, 68);
            n = $urandom_range(1, 3);
            for (int w = 0; w < n; w++) fw[w] = DW'($urandom_range(0, 63));
            frame_open(a);
            frame_words(a, n);
            frame_tail($urandom_range(0, 5));
            frame_close();
            check_all("R2 R3 R4 R5 random frame");
            if ((it % 4) == 3) begin
                field(3);
                check_all("R7 R8 random field");
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule